// File: doc/BRIEF.md
# Eight-Step Non-Binary Cycle Counter

This block is a 4-bit synchronous counter. It does not count in binary. Instead it walks a fixed loop of eight codes, taking one step on each clock edge where the count enable is high. The reset value is a non-zero code. The counter can be used as a small sequencer, where each code is decoded downstream as a phase.

Eight of the sixteen 4-bit codes are never part of the loop. A decoder flags those codes at once. A recovery policy, fixed at build time by a parameter, then decides what happens. The counter can lock up until reset, it can reload its reset code, or it can jump to a chosen loop code. Only the trap policy uses the registered trapped flag.

Top module: `ascnt_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge loads `state_o` = 4'b1000 and clears `trapped_o`. This holds from any prior state, including a trapped one. The bit string is written most significant bit first, so `state_o[3]` is the leftmost bit.
- R2: With `cnt_en` high and a loop code held, each edge moves to the successor code. The loop is 1000 → 1010 → 0010 → 0110 → 0100 → 0101 → 0001 → 1001, and 1001 returns to 1000.
- R3: With `cnt_en` low, a loop code is held unchanged across the edge.
- R4: `illegal_o` is combinational. It is 1 exactly when `state_o` is one of 0000, 0011, 0111, 1011, 1100, 1101, 1110 or 1111, and it is 0 for the eight loop codes.
- R5: When `POLICY` = 0 (trap), the first edge that sees an unused code sets `trapped_o`. From then on, `state_o` keeps that code and `trapped_o` stays 1 whatever `cnt_en` does, until R1 clears both.
- R6: When `POLICY` = 1 (reseed), an unused code is replaced by 1000 on the next edge, whatever the value of `cnt_en`.
- R7: When `POLICY` = 2 (jump), an unused code is replaced by `JUMP_CODE` on the next edge, whatever the value of `cnt_en`. `JUMP_CODE` must be a loop code and defaults to 1000.
- R8: When `POLICY` is 1 or 2, `trapped_o` is never set, and an unused code lasts for no more than one clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset; hold it low at power-up |
| cnt_en | input | 1 | Step enable for loop codes |
| state_o | output | 4 | Current counter code |
| illegal_o | output | 1 | Current code is outside the loop |
| trapped_o | output | 1 | Counter is locked (trap policy only) |

## Verification
The assertions take for granted that the register leaves the loop only through an outside upset. They never expect the next-state logic to produce an unused code. For this reason the stepping and holding properties allow the next code to be either the expected loop code or an unused one. The bench keeps to this by placing an unused code straight into the state register, just after a clock edge. It always does so from a freshly reset counter, so a trap is never started while another is still active. It also leaves at least one edge between placements, so every recovery edge can be observed.

// File: rtl/ascnt_pkg.sv
// Package: shared code type, loop table and recovery policy encoding for the
// non-binary cycle counter. Assumes a 4-bit code with an eight-entry loop.
package ascnt_pkg;

    localparam int CODE_W  = 4;
    localparam int SEQ_LEN = 8;

    typedef logic [CODE_W-1:0] code_t;

    // Value loaded by reset; deliberately non-zero.
    localparam code_t SEED = 4'b1000;

    // Recovery policy applied when the register holds an unused code.
    typedef enum logic [1:0] {
        POL_TRAP  = 2'd0,
        POL_RESET = 2'd1,
        POL_JUMP  = 2'd2
    } policy_e;

    // Loop order: entry i is followed by entry (i+1) mod SEQ_LEN.
    localparam code_t CYCLE [SEQ_LEN] = '{
        4'b1000, 4'b1010, 4'b0010, 4'b0110,
        4'b0100, 4'b0101, 4'b0001, 4'b1001
    };

endpackage

// File: rtl/ascnt_decode.sv
// Module: compares the current code against every loop entry.
// Produces a one-hot match vector (all zero for an unused code) and the
// illegal flag. Purely combinational; assumes entries of CYCLE are distinct.
module ascnt_decode
    import ascnt_pkg::*;
(
    input  code_t              cur_i,
    output logic [SEQ_LEN-1:0] hit_o,
    output logic               illegal_o
);

    // One comparator per loop entry.
    for (genvar i = 0; i < SEQ_LEN; i++) begin : g_match
        assign hit_o[i] = (cur_i == CYCLE[i]);
    end

    // Unused code: no comparator matched.
    assign illegal_o = ~|hit_o;

endmodule

// File: rtl/ascnt_succ.sv
// Module: turns the one-hot match vector into the successor code.
// Assumes at most one hit bit is set; an all-zero vector yields 0000,
// which the policy stage never selects in that case.
module ascnt_succ
    import ascnt_pkg::*;
(
    input  logic [SEQ_LEN-1:0] hit_i,
    output code_t              succ_o
);

    localparam int LAST = SEQ_LEN - 1;

    code_t part [SEQ_LEN];

    // Each matching entry contributes the code that follows it.
    for (genvar i = 0; i < SEQ_LEN; i++) begin : g_pick
        localparam int NXT = (i == LAST) ? 0 : i + 1;
        assign part[i] = hit_i[i] ? CYCLE[NXT] : '0;
    end

    // OR-merge the contributions (only one is non-zero).
    always_comb begin
        succ_o = '0;
        for (int i = 0; i < SEQ_LEN; i++) begin
            succ_o = succ_o | part[i];
        end
    end

endmodule

// File: rtl/ascnt_policy.sv
// Module: selects the next register contents from the current code, its
// successor, the enable and the illegal/trapped status.
// POLICY picks the unused-code action at build time; JUMP_CODE must be a
// loop code. Priority: trapped hold > unused-code action > enable step > hold.
module ascnt_policy
    import ascnt_pkg::*;
#(
    parameter policy_e POLICY    = POL_JUMP,
    parameter code_t   JUMP_CODE = SEED
) (
    input  logic  en_i,
    input  logic  illegal_i,
    input  logic  trapped_i,
    input  code_t cur_i,
    input  code_t succ_i,
    output code_t nxt_o,
    output logic  trap_nxt_o
);

    code_t on_bad;      // code loaded when the current code is unused
    logic  bad_traps;   // unused code starts a trap

    // Build-time choice of the unused-code action.
    if (POLICY == POL_TRAP) begin : g_trap
        assign on_bad    = cur_i;
        assign bad_traps = 1'b1;
    end else if (POLICY == POL_RESET) begin : g_reseed
        assign on_bad    = SEED;
        assign bad_traps = 1'b0;
    end else begin : g_jump
        assign on_bad    = JUMP_CODE;
        assign bad_traps = 1'b0;
    end

    // Next-state selection in priority order.
    always_comb begin
        nxt_o      = cur_i;
        trap_nxt_o = trapped_i;
        if (trapped_i) begin
            nxt_o = cur_i;
        end else if (illegal_i) begin
            nxt_o      = on_bad;
            trap_nxt_o = bad_traps;
        end else if (en_i) begin
            nxt_o = succ_i;
        end
    end

endmodule

// File: rtl/ascnt_state_reg.sv
// Module: state and trap storage with synchronous active-low reset.
// Reset loads SEED and clears the trap; no power-up value is assumed.
module ascnt_state_reg
    import ascnt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  code_t nxt_i,
    input  logic  trap_nxt_i,
    output code_t state_q,
    output logic  trapped_q
);

    // Register the selected next code and trap status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEED;
            trapped_q <= 1'b0;
        end else begin
            state_q   <= nxt_i;
            trapped_q <= trap_nxt_i;
        end
    end

endmodule

// File: rtl/ascnt_counter.sv
// Module: top of the eight-step non-binary cycle counter.
// Chains decode -> successor -> policy -> register. Assumes rst_n is held
// low for at least one clock edge at power-up; JUMP_CODE must be a loop code.
module ascnt_counter
    import ascnt_pkg::*;
#(
    parameter policy_e POLICY    = POL_JUMP,
    parameter code_t   JUMP_CODE = SEED
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cnt_en,
    output logic [3:0]  state_o,
    output logic        illegal_o,
    output logic        trapped_o
);

    code_t              cur;
    code_t              succ;
    code_t              nxt;
    logic [SEQ_LEN-1:0] hit;
    logic               bad;
    logic               trap_nxt;
    logic               trapped;

    ascnt_decode u_dec (
        .cur_i     (cur),
        .hit_o     (hit),
        .illegal_o (bad)
    );

    ascnt_succ u_succ (
        .hit_i  (hit),
        .succ_o (succ)
    );

    ascnt_policy #(
        .POLICY    (POLICY),
        .JUMP_CODE (JUMP_CODE)
    ) u_pol (
        .en_i       (cnt_en),
        .illegal_i  (bad),
        .trapped_i  (trapped),
        .cur_i      (cur),
        .succ_i     (succ),
        .nxt_o      (nxt),
        .trap_nxt_o (trap_nxt)
    );

    ascnt_state_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt_i      (nxt),
        .trap_nxt_i (trap_nxt),
        .state_q    (cur),
        .trapped_q  (trapped)
    );

    // Drive outputs from the register and decoder.
    assign state_o   = cur;
    assign illegal_o = bad;
    assign trapped_o = trapped;

endmodule

// File: rtl/ascnt_checker.sv
// Module: property checker for ascnt_counter, attached by bind below.
// Assumes unused codes appear only through an external upset of the register.
module ascnt_checker
    import ascnt_pkg::*;
#(
    parameter policy_e POLICY    = POL_JUMP,
    parameter code_t   JUMP_CODE = SEED
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_en,
    input logic [3:0] state_o,
    input logic       illegal_o,
    input logic       trapped_o
);

    // Independent successor table written as a case.
    function automatic logic [3:0] ref_next(input logic [3:0] c);
        case (c)
            4'b1000: ref_next = 4'b1010;
            4'b1010: ref_next = 4'b0010;
            4'b0010: ref_next = 4'b0110;
            4'b0110: ref_next = 4'b0100;
            4'b0100: ref_next = 4'b0101;
            4'b0101: ref_next = 4'b0001;
            4'b0001: ref_next = 4'b1001;
            4'b1001: ref_next = 4'b1000;
            default: ref_next = c;
        endcase
    endfunction

    // Loop-membership test written as a case.
    function automatic logic ref_legal(input logic [3:0] c);
        case (c)
            4'b1000, 4'b1010, 4'b0010, 4'b0110,
            4'b0100, 4'b0101, 4'b0001, 4'b1001: ref_legal = 1'b1;
            default:                             ref_legal = 1'b0;
        endcase
    endfunction

    // R1: reset edge loads the seed and clears the trap
    p_reset_seed_r1: assert property (@(posedge clk)
        !rst_n |=> (state_o == 4'b1000 && !trapped_o && !illegal_o));

    // R2: enabled loop code advances (or is upset to an unused code)
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && ref_legal(state_o) && !trapped_o)
        |=> (state_o == ref_next($past(state_o)) || !ref_legal(state_o)));

    // R3: disabled loop code holds (or is upset to an unused code)
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && ref_legal(state_o))
        |=> ($stable(state_o) || !ref_legal(state_o)));

    // R4: illegal flag matches loop membership
    p_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o == !ref_legal(state_o));

    if (POLICY == POL_TRAP) begin : g_trap_chk
        // R5: an unused code locks the counter on the next edge
        p_trap_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (illegal_o && !trapped_o) |=> (trapped_o && $stable(state_o)));

        // R5: once locked, stays locked with a frozen code
        p_trap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            trapped_o |=> (trapped_o && $stable(state_o)));
    end else begin : g_recover_chk
        // R8: no trap outside trap mode
        p_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !trapped_o);

        // R8: an unused code lasts at most one period
        p_one_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
            illegal_o |=> !illegal_o);

        if (POLICY == POL_RESET) begin : g_reseed_chk
            // R6: unused code reloads the seed
            p_reseed_r6: assert property (@(posedge clk) disable iff (!rst_n)
                illegal_o |=> (state_o == 4'b1000));
        end else begin : g_jump_chk
            // R7: unused code jumps to the configured loop code
            p_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
                illegal_o |=> (state_o == JUMP_CODE));
        end
    end

endmodule

bind ascnt_counter ascnt_checker #(
    .POLICY    (POLICY),
    .JUMP_CODE (JUMP_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .state_o   (state_o),
    .illegal_o (illegal_o),
    .trapped_o (trapped_o)
);

// File: tb/ascnt_counter_tb_top.sv
`timescale 1ns/1ps
// Bench: three counters (trap, reseed, jump) share clock, reset and enable.
// A driver pushes expected results into a scoreboard queue; a monitor pops
// and compares them after each edge.
module ascnt_counter_tb_top;

    localparam logic [3:0] JMP = 4'b0110;

    typedef struct {
        int         inst;
        logic [3:0] st;
        logic       il;
        logic       tr;
        int         due;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b0;
    logic [3:0] inj_code = 4'b0000;

    logic [3:0] st_w [3];
    logic       il_w [3];
    logic       tr_w [3];

    logic [3:0] m_state [3];
    logic       m_trap [3];
    int         pol [3] = '{0, 1, 2};

    exp_t sb_q [$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    logic [3:0] ref_seq [8] = '{4'b1000, 4'b1010, 4'b0010, 4'b0110,
                                4'b0100, 4'b0101, 4'b0001, 4'b1001};
    logic [3:0] bad_codes [8] = '{4'b0000, 4'b0011, 4'b0111, 4'b1011,
                                  4'b1100, 4'b1101, 4'b1110, 4'b1111};

    always #2 clk = ~clk;   // 250 MHz

    ascnt_counter #(.POLICY(ascnt_pkg::POL_TRAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
        .state_o(st_w[0]), .illegal_o(il_w[0]), .trapped_o(tr_w[0]));

    ascnt_counter #(.POLICY(ascnt_pkg::POL_RESET)) dut_rs_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
        .state_o(st_w[1]), .illegal_o(il_w[1]), .trapped_o(tr_w[1]));

    ascnt_counter #(.POLICY(ascnt_pkg::POL_JUMP), .JUMP_CODE(JMP)) dut_jp_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
        .state_o(st_w[2]), .illegal_o(il_w[2]), .trapped_o(tr_w[2]));

    function automatic logic ref_legal(input logic [3:0] c);
        ref_legal = 1'b0;
        for (int k = 0; k < 8; k++) if (ref_seq[k] == c) ref_legal = 1'b1;
    endfunction

    function automatic logic [3:0] ref_succ(input logic [3:0] c);
        ref_succ = c;
        for (int k = 0; k < 8; k++) if (ref_seq[k] == c) ref_succ = ref_seq[(k + 1) % 8];
    endfunction

    // Reference model: one edge for instance i with enable e.
    task automatic model_step(input int i, input logic e);
        if (m_trap[i]) begin
        end else if (!ref_legal(m_state[i])) begin
            if (pol[i] == 0)      m_trap[i] = 1'b1;
            else if (pol[i] == 1) m_state[i] = 4'b1000;
            else                  m_state[i] = JMP;
        end else if (e) begin
            m_state[i] = ref_succ(m_state[i]);
        end
    endtask

    task automatic push_all(input string r0, input string r1, input string r2);
        string rq [3];
        rq[0] = r0; rq[1] = r1; rq[2] = r2;
        for (int i = 0; i < 3; i++) begin
            exp_t it;
            it.inst = i;
            it.st   = m_state[i];
            it.il   = !ref_legal(m_state[i]);
            it.tr   = m_trap[i];
            it.due  = cyc + 1;
            it.req  = rq[i];
            sb_q.push_back(it);
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: one edge with the given enable.
    task automatic tick(input logic e, input string r0, input string r1, input string r2);
        @(posedge clk); #1;
        cnt_en = e;
        for (int i = 0; i < 3; i++) model_step(i, e);
        push_all(r0, r1, r2);
    endtask

    // Driver: reset edge (R1), then release.
    task automatic do_reset();
        @(posedge clk); #1;
        rst_n  = 1'b0;
        cnt_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            m_state[i] = 4'b1000;
            m_trap[i]  = 1'b0;
        end
        push_all("R1", "R1", "R1");
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    // Driver: upset all registers to an unused code, then one edge.
    task automatic inject(input logic [3:0] code, input logic e);
        @(posedge clk); #1;
        cnt_en   = e;
        inj_code = code;
        force dut_i.u_reg.state_q = inj_code;
        force dut_rs_i.u_reg.state_q = inj_code;
        force dut_jp_i.u_reg.state_q = inj_code;
        #0;
        release dut_i.u_reg.state_q;
        release dut_rs_i.u_reg.state_q;
        release dut_jp_i.u_reg.state_q;
        for (int i = 0; i < 3; i++) m_state[i] = code;
        #1;
        for (int i = 0; i < 3; i++)
            chk(il_w[i] == 1'b1 && st_w[i] == code, "R4", "illegal flag on upset",
                {il_w[i], st_w[i]}, {1'b1, code});
        for (int i = 0; i < 3; i++) model_step(i, e);
        push_all("R5", "R6", "R7");
    endtask

    // Monitor: pop and compare items that are due after each edge.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                exp_t it;
                it = sb_q.pop_front();
                chk(st_w[it.inst] == it.st && il_w[it.inst] == it.il &&
                    tr_w[it.inst] == it.tr, it.req,
                    $sformatf("inst %0d {state,illegal,trapped}", it.inst),
                    {st_w[it.inst], il_w[it.inst], tr_w[it.inst]},
                    {it.st, it.il, it.tr});
            end
        end
    end

    // Stimulus.
    initial begin
        do_reset();                                     // R1 initial reset
        for (int n = 0; n < 16; n++) tick(1'b1, "R2", "R2", "R2");  // two loops
        for (int n = 0; n < 3; n++)  tick(1'b0, "R3", "R3", "R3");  // hold
        for (int n = 0; n < 6; n++)  tick(n[0], "R3", "R3", "R3");  // alternate
        do_reset();                                     // R1 from mid-loop
        for (int k = 0; k < 8; k++) begin
            inject(bad_codes[k], k[0]);                 // R5 R6 R7 response
            tick(!k[0], "R5", "R8", "R8");              // R5 enable ignored
            tick(1'b1, "R5", "R8", "R8");               // R8 no trap, stays legal
            do_reset();                                 // R1 clears trap
        end
        tick(1'b1, "R2", "R2", "R2");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule